// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one memory request from a 32-lane warp, which is a byte address for every lane plus a mask of the lanes that take part. It folds together the active lanes whose addresses land in the same aligned 128-byte segment. It then issues the smallest possible set of segment transactions, one per cycle, and each transaction carries the lanes it serves. When every lane reads a consecutive 4-byte word inside one segment, the request collapses to a single transaction. When the lanes are spread over different segments, it expands to as many as 32 transactions.

A producer hands over a request through a valid/ready pair. A downstream memory port takes the transactions through a second valid/ready pair. When a request is finished, the block pulses a completion flag and reports how many transactions the request needed. From that count, useful bytes divided by count times 128 gives the access efficiency.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready_o is 1, txn_valid_o is 0, done_o is 0 and count_o is 0.
- R2: Each transaction's txn_base_o is a lane address with its low log2(SEG_BYTES) bits (7 by default) cleared. Bit i of txn_lanes_o is set exactly when lane i is active, has not yet been served, and its address has that segment base.
- R3: When all 32 lanes are active and lane i addresses B + 4*i with B 128-byte aligned, exactly one transaction with all lanes set is produced.
- R4: When every active lane addresses a different segment, one transaction per active lane is produced.
- R5: A lane whose bit in req_mask_i is 0 never appears in a lane bitmap, and its address never causes a transaction.
- R6: A request with an all-zero mask produces no transaction. done_o pulses with count_o equal to 0.
- R7: The transactions of one request come out in increasing order of the lowest-numbered active lane that each one serves.
- R8: The lane bitmaps of one request are pairwise disjoint, and their union equals the request's mask.
- R9: req_ready_o is 0 from the cycle after a request is accepted until the cycle after its final transaction handshake, so no new request is taken meanwhile.
- R10: While txn_valid_o is 1 and txn_ready_i is 0, txn_valid_o, txn_base_o and txn_lanes_o hold their values into the next cycle.
- R11: done_o is high for exactly one cycle. That cycle follows either the final transaction handshake or the acceptance of an empty request. count_o then equals the number of transactions and holds until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block can accept a request |
| req_mask_i | input | LANES | Active lane mask |
| req_addr_i | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| txn_valid_o | output | 1 | Transaction offered |
| txn_ready_i | input | 1 | Downstream takes the transaction |
| txn_base_o | output | ADDR_W | Aligned segment base address |
| txn_lanes_o | output | LANES | Lanes served by this transaction |
| done_o | output | 1 | One-cycle pulse when a request completes |
| count_o | output | $clog2(LANES+1) | Transactions generated for the last completed request |

## Verification
The bench targets the following cases:
- An unaligned run of consecutive words that straddles two segments. A design that compared whole addresses, or that split on the wrong bit, would emit the wrong number of transactions.
- A reversed scatter and an even/odd interleave. A coalescer that emits segments in address order, rather than in lane order, would show up here.
- Half-masked requests and an empty request whose inactive lanes point at foreign segments. A design that ignored the mask would emit extra transactions or leak lanes into a bitmap.
- A long sweep of random masks, random addresses confined to a few segments and random backpressure. This checks that held outputs stay stable, that bitmaps never overlap or omit a lane, and that the done pulse and its count line up with the final handshake.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coal_state_e;
endpackage

// File: rtl/coal_leader_pick.sv
// Lowest set bit of the pending mask selects the lane that leads the next segment.
module coal_leader_pick #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     pend_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/coal_seg_match.sv
module coal_seg_match #(
  parameter int N     = 32,
  parameter int SEG_W = 25
) (
  input  logic [N*SEG_W-1:0] seg_i,
  input  logic [N-1:0]       pend_i,
  input  logic [SEG_W-1:0]   leader_seg_i,
  output logic [N-1:0]       match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = pend_i[g] && (seg_i[g*SEG_W +: SEG_W] == leader_seg_i);
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 32,
  parameter int SEG_BYTES = 128,
  localparam int OFS_W    = $clog2(SEG_BYTES),
  localparam int SEG_W    = ADDR_W - OFS_W,
  localparam int IDX_W    = $clog2(LANES),
  localparam int CNT_W    = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [LANES-1:0]        req_mask_i,
  input  logic [LANES*ADDR_W-1:0] req_addr_i,
  output logic                    txn_valid_o,
  input  logic                    txn_ready_i,
  output logic [ADDR_W-1:0]       txn_base_o,
  output logic [LANES-1:0]        txn_lanes_o,
  output logic                    done_o,
  output logic [CNT_W-1:0]        count_o
);
  coal_state_e             state_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        pend_q;
  logic [CNT_W-1:0]        count_q;
  logic                    done_q;

  logic [LANES*SEG_W-1:0]  seg_vec;
  logic [IDX_W-1:0]        leader_idx;
  logic [ADDR_W-1:0]       leader_addr;
  logic [LANES-1:0]        match;
  logic [LANES-1:0]        pend_left;
  logic                    accept;
  logic                    fire;

  for (genvar g = 0; g < LANES; g++) begin : g_seg
    assign seg_vec[g*SEG_W +: SEG_W] = addr_q[g*ADDR_W + OFS_W +: SEG_W];
  end

  coal_leader_pick #(
    .N     (LANES),
    .IDX_W (IDX_W)
  ) u_pick (
    .pend_i (pend_q),
    .idx_o  (leader_idx)
  );

  assign leader_addr = addr_q[leader_idx*ADDR_W +: ADDR_W];

  coal_seg_match #(
    .N     (LANES),
    .SEG_W (SEG_W)
  ) u_match (
    .seg_i        (seg_vec),
    .pend_i       (pend_q),
    .leader_seg_i (leader_addr[ADDR_W-1:OFS_W]),
    .match_o      (match)
  );

  assign pend_left   = pend_q & ~match;
  assign req_ready_o = (state_q == ST_IDLE);
  assign txn_valid_o = (state_q == ST_BUSY);
  assign txn_base_o  = leader_addr & ~ADDR_W'(SEG_BYTES - 1);
  assign txn_lanes_o = match;
  assign done_o      = done_q;
  assign count_o     = count_q;
  assign accept      = req_valid_i && req_ready_o;
  assign fire        = txn_valid_o && txn_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pend_q  <= '0;
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        addr_q  <= req_addr_i;
        pend_q  <= req_mask_i;
        count_q <= '0;
        if (req_mask_i == '0) done_q <= 1'b1;
        else                  state_q <= ST_BUSY;
      end else if (fire) begin
        pend_q  <= pend_left;
        count_q <= count_q + CNT_W'(1);
        if (pend_left == '0) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [LANES-1:0]  req_mask_i,
  input logic              txn_valid_o,
  input logic              txn_ready_i,
  input logic [ADDR_W-1:0] txn_base_o,
  input logic [LANES-1:0]  txn_lanes_o,
  input logic              done_o
);
  logic [LANES-1:0] cap_q, served_q, remain, low_remain, low_lanes;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q    <= '0;
      served_q <= '0;
    end else if (req_valid_i && req_ready_o) begin
      cap_q    <= req_mask_i;
      served_q <= '0;
    end else if (txn_valid_o && txn_ready_i) begin
      served_q <= served_q | txn_lanes_o;
    end
  end

  assign remain     = cap_q & ~served_q;
  assign low_remain = remain & (~remain + 1'b1);
  assign low_lanes  = txn_lanes_o & (~txn_lanes_o + 1'b1);

  a_r2_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> txn_base_o[OFS_W-1:0] == '0);

  a_r5_only_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> (txn_lanes_o & ~cap_q) == '0 && txn_lanes_o != '0);

  a_r7_lane_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> low_lanes == low_remain);

  a_r8_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> (txn_lanes_o & served_q) == '0);

  a_r9_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && txn_valid_o));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_base_o) && $stable(txn_lanes_o));

  a_r11_done_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o && served_q == cap_q);
endmodule

bind warp_coalescer warp_coalescer_chk #(
  .LANES  (LANES),
  .ADDR_W (ADDR_W),
  .OFS_W  (OFS_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_mask_i  (req_mask_i),
  .txn_valid_o (txn_valid_o),
  .txn_ready_i (txn_ready_i),
  .txn_base_o  (txn_base_o),
  .txn_lanes_o (txn_lanes_o),
  .done_o      (done_o)
);

// File: tb/sim_warp_coalescer.sv
module sim_warp_coalescer;
  localparam int L  = 32;
  localparam int AW = 32;
  localparam int CW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [L-1:0]    req_mask = '0;
  logic [L*AW-1:0] req_addr = '0;
  logic            txn_valid;
  logic            txn_ready = 1'b0;
  logic [AW-1:0]   txn_base;
  logic [L-1:0]    txn_lanes;
  logic            done;
  logic [CW-1:0]   count;

  warp_coalescer u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_mask_i  (req_mask),
    .req_addr_i  (req_addr),
    .txn_valid_o (txn_valid),
    .txn_ready_i (txn_ready),
    .txn_base_o  (txn_base),
    .txn_lanes_o (txn_lanes),
    .done_o      (done),
    .count_o     (count)
  );

  always #5 clk = ~clk;

  int          tests = 0;
  int          fails = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] a [L];
  logic [L-1:0] m;
  logic [31:0] exp_base [L];
  logic [L-1:0] exp_lanes [L];
  int          exp_n;
  bit          bp = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic step_seed();
    seed = seed * 32'd1103515245 + 32'd12345;
  endtask

  task automatic build_exp();
    logic [L-1:0] pend;
    pend  = m;
    exp_n = 0;
    while (pend != '0) begin
      int ld;
      logic [24:0] sg;
      logic [L-1:0] ln;
      ld = 0;
      for (int i = L - 1; i >= 0; i--) if (pend[i]) ld = i;
      sg = a[ld][31:7];
      ln = '0;
      for (int i = 0; i < L; i++) if (pend[i] && a[i][31:7] == sg) ln[i] = 1'b1;
      exp_base[exp_n]  = {sg, 7'd0};
      exp_lanes[exp_n] = ln;
      pend = pend & ~ln;
      exp_n++;
    end
  endtask

  task automatic run_req(input string tag);
    int j;
    bit stalled;
    logic [31:0]  hb;
    logic [L-1:0] hl, uni;
    build_exp();
    @(negedge clk);
    for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = a[i];
    req_mask  = m;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R9 ready idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    j = 0; stalled = 1'b0; uni = '0; hb = '0; hl = '0;
    while (j < exp_n) begin
      chk(req_ready == 1'b0 && txn_valid == 1'b1, "R9 busy", {62'd0, req_ready, txn_valid}, 64'd1);
      if (stalled)
        chk(txn_base == hb && txn_lanes == hl, "R10 hold", {txn_base, txn_lanes}, {hb, hl});
      step_seed();
      txn_ready = bp ? seed[16] : 1'b1;
      if (txn_ready) begin
        chk(txn_base == exp_base[j], "R2 R7 base", 64'(txn_base), 64'(exp_base[j]));
        chk(txn_lanes == exp_lanes[j], "R2 R7 lanes", 64'(txn_lanes), 64'(exp_lanes[j]));
        uni = uni | txn_lanes;
        stalled = 1'b0;
        j++;
      end else begin
        stalled = 1'b1;
        hb = txn_base;
        hl = txn_lanes;
      end
      @(negedge clk);
    end
    txn_ready = 1'b0;
    chk(done == 1'b1, "R11 done pulse", 64'(done), 64'd1);
    chk(count == CW'(exp_n), {tag, " count"}, 64'(count), 64'(exp_n));
    chk(req_ready == 1'b1, "R9 ready after", 64'(req_ready), 64'd1);
    chk(uni == m, "R8 union", 64'(uni), 64'(m));
    @(negedge clk);
    chk(done == 1'b0 && count == CW'(exp_n), "R11 pulse width", {57'd0, done, count}, 64'(exp_n));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !txn_valid && !done && count == '0, "R1 reset",
        {56'd0, req_ready, txn_valid, done, count[4:0]}, 64'h80);

    // R3: consecutive words
    for (int i = 0; i < L; i++) a[i] = 32'h1000 + 32'(4 * i);
    m = '1; run_req("R3");
    // R4: each lane its own segment
    for (int i = 0; i < L; i++) a[i] = 32'h2_0000 + 32'(128 * i) + 32'(i);
    m = '1; run_req("R4");
    // R4 R7: reversed order of segments
    for (int i = 0; i < L; i++) a[i] = 32'((31 - i) * 256);
    m = '1; run_req("R4 R7");
    // R2: stride 8 spans two segments
    for (int i = 0; i < L; i++) a[i] = 32'h400 + 32'(8 * i);
    m = '1; run_req("R2 stride");
    // R2: unaligned run straddling a boundary
    for (int i = 0; i < L; i++) a[i] = 32'h40 + 32'(4 * i);
    m = '1; run_req("R2 straddle");
    // R5: inactive lanes point elsewhere
    for (int i = 0; i < L; i++) a[i] = (i < 16) ? 32'h2000 + 32'(4 * i) : 32'(i * 4096);
    m = 32'h0000_FFFF; run_req("R5");
    // R6: empty mask
    for (int i = 0; i < L; i++) a[i] = 32'(i * 4096);
    m = '0; run_req("R6");
    // R5: single top lane
    m = 32'h8000_0000; run_req("R5 single");
    // R7: even/odd interleave
    for (int i = 0; i < L; i++) a[i] = 32'((i % 2) * 128 + i * 4);
    m = '1; run_req("R7 interleave");
    // sweep with backpressure
    bp = 1'b1;
    for (int t = 0; t < 400; t++) begin
      for (int i = 0; i < L; i++) begin
        step_seed();
        a[i] = {23'd0, seed[24:16]};
      end
      step_seed();
      m = seed;
      if (t % 37 == 0) m = '0;
      if (t % 41 == 0) m = '1;
      run_req("R2 R8 sweep");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule